// File: doc/BRIEF.md
# MAC address table command engine

A compact forwarding-database engine for an Ethernet switch. Software reaches it through a small 16-bit register window: an operation word with a busy flag, an entry data word and three address words that together hold a 48-bit station address. Each entry in the internal table holds a 6-bit database number, the station address, a 4-bit entry state, a trunk flag and a port vector. A state of zero marks an empty slot.

Writing the operation word with the busy flag set starts a command. The engine then walks the whole table, one slot per clock, and applies the command. The four commands are: load or purge one entry; step to the next entry of a database in ascending address order; flush entries; and move entries from one port to another. Flush and move share one command. The state field of the data word selects between them. The opcode selects whether every entry or only the non-static entries are covered, and whether one database or all databases are covered. Software polls the busy flag before it issues the next command.

Register map (addr_i): 0 operation, 1 data, 2 address bytes 0/1, 3 address bytes 2/3, 4 address bytes 4/5. Reads of any other address return zero.

Top module: `mac_tbl_engine`

## Requirements
- R1: A write of the operation word (address 0) with bit 15 set while idle starts a command. Bit 15 of the operation read-back and busy_o are both 1 until the command completes. Bits 14:12 hold the opcode: 3 = load/purge, 4 = get-next, 1 = flush/move all entries in all databases, 2 = flush/move non-static entries in all databases, 5 = flush/move all entries in one database, 6 = flush/move non-static entries in one database.
- R2: While busy_o is high, register writes have no effect on any register.
- R3: Address word n (addresses 2, 3, 4) holds byte 2n in bits 15:8 and byte 2n+1 in bits 7:0. Byte 0 is the most significant byte for ordering.
- R4: A load with a non-zero state (data bits 3:0) creates the entry for the addressed database and MAC, or overwrites it if it already exists.
- R5: A load with state 0 removes the entry that matches the database and MAC.
- R6: In the data word, the trunk flag is bit 15 and the port vector starts at bit 4. The port vector is masked to NPORTS bits, so with 7 ports, bits 11 to 14 are dropped.
- R7: Get-next returns the entry with the lowest MAC that is strictly above the MAC held in the address words, within the selected database. An all-ones start MAC means "from the beginning". The entry is written back into the data and address words. When there is no such entry, the result is state 0, data 0 and an all-ones MAC.
- R8: The database number is {operation bits 9:8, operation bits 3:0}. Entries of other databases are neither returned nor modified by single-database commands.
- R9: A flush/move with data state 0 deletes every covered entry. The one-database variants leave other databases untouched.
- R10: Non-static variants skip entries whose state is 0xF.
- R11: A flush/move with data state 0xF, source port in data bits 7:4 and destination port in data bits 11:8 clears the source bit and sets the destination bit in each covered entry that has the source bit set.
- R12: A move whose destination field is 0xF only clears the source bit. An entry whose port vector becomes empty is deleted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data (combinational) |
| busy_o | output | 1 | Command in progress |

## Verification
Get-next walks are run from an all-ones start across entries whose addresses differ only in the low byte, and across entries that differ in the top byte. This separates a correct byte order from a reversed one, and a strict comparison from a non-strict one. The same MAC is loaded into two databases whose numbers differ only in the high field, which exposes a dropped bit 9:8 in the decode. Flushes mix static and dynamic entries to separate the two coverage choices. Moves use port vectors in which the destination bit is already set on an unrelated entry, and a removal that leaves one entry empty and another non-empty. Together these separate the re-point, remove and delete paths.

// File: rtl/mac_tbl_pkg.sv
package mac_tbl_pkg;
  localparam int DB_W   = 6;
  localparam int MAC_W  = 48;
  localparam int PV_MAX = 11;

  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_FM_ALL_G = 3'd1,
    OP_FM_NS_G  = 3'd2,
    OP_LOAD     = 3'd3,
    OP_GETNEXT  = 3'd4,
    OP_FM_ALL_D = 3'd5,
    OP_FM_NS_D  = 3'd6,
    OP_RSVD     = 3'd7
  } opcode_e;

  typedef struct packed {
    logic [3:0]        state;
    logic              trunk;
    logic [PV_MAX-1:0] pv;
    logic [DB_W-1:0]   db;
    logic [MAC_W-1:0]  mac;
  } entry_t;

  localparam logic [3:0] ST_EMPTY  = 4'h0;
  localparam logic [3:0] ST_STATIC = 4'hF;
endpackage

// File: rtl/mac_tbl_regs.sv
module mac_tbl_regs
  import mac_tbl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        addr_i,
  input  logic [15:0]       wdata_i,
  input  logic              busy_i,
  input  logic              upd_i,
  input  logic [15:0]       upd_data_i,
  input  logic [MAC_W-1:0]  upd_mac_i,
  output logic [15:0]       rdata_o,
  output logic              start_o,
  output opcode_e           opcode_o,
  output logic [DB_W-1:0]   db_o,
  output logic [15:0]       data_o,
  output logic [MAC_W-1:0]  mac_o
);
  logic [14:0]      op_q;
  logic [15:0]      data_q;
  logic [MAC_W-1:0] mac_q;
  logic             wr_ok;

  assign wr_ok   = wr_en_i && !busy_i;
  assign start_o = wr_ok && (addr_i == 3'd0) && wdata_i[15];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= '0;
      data_q <= '0;
      mac_q  <= '0;
    end else if (upd_i) begin
      data_q <= upd_data_i;
      mac_q  <= upd_mac_i;
    end else if (wr_ok) begin
      case (addr_i)
        3'd0: op_q           <= wdata_i[14:0];
        3'd1: data_q         <= wdata_i;
        3'd2: mac_q[47:32]   <= wdata_i;
        3'd3: mac_q[31:16]   <= wdata_i;
        3'd4: mac_q[15:0]    <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      3'd0:    rdata_o = {busy_i, op_q};
      3'd1:    rdata_o = data_q;
      3'd2:    rdata_o = mac_q[47:32];
      3'd3:    rdata_o = mac_q[31:16];
      3'd4:    rdata_o = mac_q[15:0];
      default: rdata_o = '0;
    endcase
  end

  assign opcode_o = opcode_e'(op_q[14:12]);
  assign db_o     = {op_q[9:8], op_q[3:0]};
  assign data_o   = data_q;
  assign mac_o    = mac_q;
endmodule

// File: rtl/mac_tbl_store.sv
module mac_tbl_store
  import mac_tbl_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] rd_idx_i,
  output entry_t        rd_ent_o,
  input  logic          we_i,
  input  logic [IW-1:0] w_idx_i,
  input  entry_t        w_ent_i
);
  entry_t mem_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mem_q[g] <= '0;
      else if (we_i && (w_idx_i == IW'(g)))
        mem_q[g] <= w_ent_i;
    end
  end

  assign rd_ent_o = mem_q[rd_idx_i];
endmodule

// File: rtl/mac_tbl_seq.sv
module mac_tbl_seq
  import mac_tbl_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int NPORTS  = 7,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  opcode_e           opcode_i,
  input  logic [DB_W-1:0]   db_i,
  input  logic [15:0]       data_i,
  input  logic [MAC_W-1:0]  mac_i,
  output logic [IW-1:0]     idx_o,
  input  entry_t            ent_i,
  output logic              we_o,
  output logic [IW-1:0]     w_idx_o,
  output entry_t            w_ent_o,
  output logic              busy_o,
  output logic              upd_o,
  output logic [15:0]       upd_data_o,
  output logic [MAC_W-1:0]  upd_mac_o
);
  typedef enum logic [1:0] {PH_IDLE, PH_SCAN, PH_FIN} phase_e;

  localparam logic [PV_MAX-1:0] PMASK = PV_MAX'((1 << NPORTS) - 1);
  localparam logic [IW-1:0]     LAST  = IW'(ENTRIES - 1);

  phase_e          ph_q;
  logic [IW-1:0]   idx_q;
  logic            hit_v_q, free_v_q, best_v_q;
  logic [IW-1:0]   hit_idx_q, free_idx_q;
  entry_t          best_q;

  logic            valid, db_eq, mac_eq, mac_gt, mac_lt_best, start_all1;
  logic            fm_cmd, fm_alldb, fm_allent, fm_sel;
  logic [3:0]      from_p, to_p;
  logic [PV_MAX-1:0] from_bit, to_bit, new_pv;
  logic            scan_we;
  entry_t          scan_ent, load_ent;

  assign valid       = ent_i.state != ST_EMPTY;
  assign db_eq       = ent_i.db == db_i;
  assign mac_eq      = ent_i.mac == mac_i;
  assign start_all1  = &mac_i;
  assign mac_gt      = start_all1 || (ent_i.mac > mac_i);
  assign mac_lt_best = !best_v_q || (ent_i.mac < best_q.mac);

  assign fm_cmd    = (opcode_i == OP_FM_ALL_G) || (opcode_i == OP_FM_NS_G) ||
                     (opcode_i == OP_FM_ALL_D) || (opcode_i == OP_FM_NS_D);
  assign fm_alldb  = !opcode_i[2];
  assign fm_allent = opcode_i[1:0] == 2'b01;
  assign fm_sel    = valid && (fm_alldb || db_eq) && (fm_allent || ent_i.state != ST_STATIC);

  assign from_p   = data_i[7:4];
  assign to_p     = data_i[11:8];
  assign from_bit = (PV_MAX'(1) << from_p) & PMASK;
  assign to_bit   = (to_p == 4'hF) ? '0 : ((PV_MAX'(1) << to_p) & PMASK);
  assign new_pv   = (ent_i.pv & ~from_bit) | to_bit;

  // flush/move edits happen in place during the scan
  always_comb begin
    scan_we  = 1'b0;
    scan_ent = ent_i;
    if (ph_q == PH_SCAN && fm_cmd && fm_sel) begin
      if (data_i[3:0] == ST_EMPTY) begin
        scan_we        = 1'b1;
        scan_ent       = '0;
      end else if (data_i[3:0] == ST_STATIC && |(ent_i.pv & from_bit)) begin
        scan_we        = 1'b1;
        scan_ent.pv    = new_pv;
        if (new_pv == '0) scan_ent = '0;
      end
    end
  end

  always_comb begin
    load_ent       = '0;
    if (data_i[3:0] != ST_EMPTY) begin
      load_ent.state = data_i[3:0];
      load_ent.trunk = data_i[15];
      load_ent.pv    = data_i[4 +: PV_MAX] & PMASK;
      load_ent.db    = db_i;
      load_ent.mac   = mac_i;
    end
  end

  always_comb begin
    we_o    = scan_we;
    w_idx_o = idx_q;
    w_ent_o = scan_ent;
    if (ph_q == PH_FIN && opcode_i == OP_LOAD) begin
      if (hit_v_q) begin
        we_o    = 1'b1;
        w_idx_o = hit_idx_q;
        w_ent_o = load_ent;
      end else if (free_v_q && data_i[3:0] != ST_EMPTY) begin
        we_o    = 1'b1;
        w_idx_o = free_idx_q;
        w_ent_o = load_ent;
      end
    end
  end

  always_comb begin
    upd_o      = (ph_q == PH_FIN) && (opcode_i == OP_GETNEXT);
    upd_data_o = '0;
    upd_mac_o  = '1;
    if (best_v_q) begin
      upd_data_o[3:0]          = best_q.state;
      upd_data_o[4 +: PV_MAX]  = best_q.pv;
      upd_data_o[15]           = best_q.trunk;
      upd_mac_o                = best_q.mac;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q       <= PH_IDLE;
      idx_q      <= '0;
      hit_v_q    <= 1'b0;
      free_v_q   <= 1'b0;
      best_v_q   <= 1'b0;
      hit_idx_q  <= '0;
      free_idx_q <= '0;
      best_q     <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: if (start_i) begin
          ph_q     <= PH_SCAN;
          idx_q    <= '0;
          hit_v_q  <= 1'b0;
          free_v_q <= 1'b0;
          best_v_q <= 1'b0;
        end
        PH_SCAN: begin
          if (opcode_i == OP_LOAD) begin
            if (!hit_v_q && valid && db_eq && mac_eq) begin
              hit_v_q   <= 1'b1;
              hit_idx_q <= idx_q;
            end
            if (!free_v_q && !valid) begin
              free_v_q   <= 1'b1;
              free_idx_q <= idx_q;
            end
          end
          if (opcode_i == OP_GETNEXT && valid && db_eq && mac_gt && mac_lt_best) begin
            best_v_q <= 1'b1;
            best_q   <= ent_i;
          end
          if (idx_q == LAST) ph_q <= PH_FIN;
          else               idx_q <= idx_q + 1'b1;
        end
        PH_FIN:  ph_q <= PH_IDLE;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign idx_o  = idx_q;
  assign busy_o = ph_q != PH_IDLE;
endmodule

// File: rtl/mac_tbl_engine.sv
module mac_tbl_engine
  import mac_tbl_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int NPORTS  = 7
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [2:0]  addr_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  output logic        busy_o
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic             start, upd, st_we;
  opcode_e          opcode;
  logic [DB_W-1:0]  db;
  logic [15:0]      reg_data, upd_data;
  logic [MAC_W-1:0] reg_mac, upd_mac;
  logic [IW-1:0]    rd_idx, w_idx;
  entry_t           rd_ent, w_ent;

  mac_tbl_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .busy_i     (busy_o),
    .upd_i      (upd),
    .upd_data_i (upd_data),
    .upd_mac_i  (upd_mac),
    .rdata_o,
    .start_o    (start),
    .opcode_o   (opcode),
    .db_o       (db),
    .data_o     (reg_data),
    .mac_o      (reg_mac)
  );

  mac_tbl_store #(.ENTRIES(ENTRIES)) u_store (
    .clk_i, .rst_ni,
    .rd_idx_i (rd_idx),
    .rd_ent_o (rd_ent),
    .we_i     (st_we),
    .w_idx_i  (w_idx),
    .w_ent_i  (w_ent)
  );

  mac_tbl_seq #(.ENTRIES(ENTRIES), .NPORTS(NPORTS)) u_seq (
    .clk_i, .rst_ni,
    .start_i    (start),
    .opcode_i   (opcode),
    .db_i       (db),
    .data_i     (reg_data),
    .mac_i      (reg_mac),
    .idx_o      (rd_idx),
    .ent_i      (rd_ent),
    .we_o       (st_we),
    .w_idx_o    (w_idx),
    .w_ent_o    (w_ent),
    .busy_o     (busy_o),
    .upd_o      (upd),
    .upd_data_o (upd_data),
    .upd_mac_o  (upd_mac)
  );
endmodule

// File: rtl/mac_tbl_chk.sv
module mac_tbl_chk #(
  parameter int ENTRIES = 8
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [2:0]  addr_i,
  input logic [15:0] wdata_i,
  input logic        busy_o,
  input logic        st_we,
  input logic [15:0] reg_data,
  input logic [47:0] reg_mac
);
  logic [15:0] busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt <= '0;
    else if (busy_o) busy_cnt <= busy_cnt + 1'b1;
    else             busy_cnt <= '0;
  end

  AST_START_SETS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 3'd0 && wdata_i[15] && !busy_o) |=> busy_o); // R1

  AST_BUSY_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_cnt <= 16'(ENTRIES + 1)); // R1

  AST_DATA_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(reg_data)); // R2

  AST_MAC_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(reg_mac)); // R2

  AST_IDLE_NO_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !st_we); // R4
endmodule

bind mac_tbl_engine mac_tbl_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .busy_o   (busy_o),
  .st_we    (st_we),
  .reg_data (reg_data),
  .reg_mac  (reg_mac)
);

// File: tb/tb_mac_tbl_engine.sv
`timescale 1ns/1ps
module tb_mac_tbl_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        busy;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  mac_tbl_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .busy_o(busy)
  );

  localparam logic [47:0] MAC_A = 48'h0011_2233_4455;
  localparam logic [47:0] MAC_B = 48'h0011_2233_4410;
  localparam logic [47:0] MAC_C = 48'h0200_0000_0001;
  localparam logic [47:0] MAC_D = 48'h0000_0000_0001;
  localparam logic [47:0] ONES  = 48'hFFFF_FFFF_FFFF;

  // monitor: pops expected items and compares against the read port
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        total++;
        if (rdata !== it.exp) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, rdata, it.exp);
        end
      end
    end
  end

  function automatic logic [15:0] opw(input logic [2:0] opc, input logic [5:0] db);
    return 16'h8000 | (16'(opc) << 12) | (16'(db[5:4]) << 8) | 16'(db[3:0]);
  endfunction

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk(input logic [2:0] a, input logic [15:0] e, input string tag);
    item_t it;
    @(negedge clk);
    addr = a;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while (busy && n < 1000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 1000) begin
      total++; bad++;
      $display("FAIL %s: actual=busy-stuck expected=idle", tag);
    end
  endtask

  task automatic set_mac(input logic [47:0] m);
    wr(3'd2, m[47:32]);
    wr(3'd3, m[31:16]);
    wr(3'd4, m[15:0]);
  endtask

  task automatic load(input logic [5:0] db, input logic [47:0] m, input logic [15:0] d);
    set_mac(m);
    wr(3'd1, d);
    wr(3'd0, opw(3'd3, db));
    wait_idle("R4 load");
  endtask

  task automatic fm(input logic [2:0] opc, input logic [5:0] db, input logic [15:0] d, input string tag);
    wr(3'd1, d);
    wr(3'd0, opw(opc, db));
    wait_idle(tag);
  endtask

  task automatic gnext(input logic [5:0] db, input logic [15:0] ed,
                       input logic [47:0] em, input string tag);
    wr(3'd0, opw(3'd4, db));
    wait_idle(tag);
    chk(3'd1, ed, tag);
    chk(3'd2, em[47:32], tag);
    chk(3'd3, em[31:16], tag);
    chk(3'd4, em[15:0], tag);
  endtask

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(3'd0, 16'h0000, "R1 reset op");
    chk(3'd1, 16'h0000, "R1 reset data");

    // R3 byte layout of address words
    set_mac(MAC_A);
    chk(3'd2, 16'h0011, "R3 word0");
    chk(3'd4, 16'h4455, "R3 word2");

    load(6'h01, MAC_A, 16'h4037);   // R6: bit 14 beyond 7 ports
    load(6'h01, MAC_B, 16'h004F);   // static, pv bit2
    load(6'h01, MAC_C, 16'h8017);   // trunk
    load(6'h12, MAC_D, 16'h0227);   // R8 high db bits

    // R2: write during busy ignored; R1: busy visible on op read-back
    set_mac(MAC_D);
    wr(3'd1, 16'h0015);
    wr(3'd0, opw(3'd3, 6'h02));
    wr(3'd1, 16'hABCD);
    chk(3'd0, opw(3'd3, 6'h02), "R1 busy bit");
    if (!busy) begin total++; bad++; $display("FAIL R1: actual=idle expected=busy"); end
    wait_idle("R2 load");
    chk(3'd0, opw(3'd3, 6'h02) & 16'h7FFF, "R1 busy cleared");
    chk(3'd1, 16'h0015, "R2 data unchanged");

    // R7 walk of db 1, R3 ordering, R6 masking
    set_mac(ONES);
    gnext(6'h01, 16'h004F, MAC_B, "R7 first");
    gnext(6'h01, 16'h0037, MAC_A, "R6 masked pv");
    gnext(6'h01, 16'h8017, MAC_C, "R6 trunk");
    gnext(6'h01, 16'h0000, ONES,  "R7 end");

    // R8 same MAC in two databases
    set_mac(ONES);
    gnext(6'h12, 16'h0227, MAC_D, "R8 db 0x12");
    gnext(6'h12, 16'h0000, ONES,  "R8 db 0x12 end");
    set_mac(ONES);
    gnext(6'h02, 16'h0015, MAC_D, "R8 db 0x02");

    // R4 overwrite, R5 purge
    load(6'h01, MAC_A, 16'h001E);
    load(6'h01, MAC_B, 16'h0000);
    set_mac(ONES);
    gnext(6'h01, 16'h001E, MAC_A, "R4 overwrite");
    gnext(6'h01, 16'h8017, MAC_C, "R5 after purge");
    gnext(6'h01, 16'h0000, ONES,  "R5 end");

    // R10 non-static flush of db 1
    load(6'h01, MAC_B, 16'h004F);
    fm(3'd6, 6'h01, 16'h0000, "R10 flush");
    set_mac(ONES);
    gnext(6'h01, 16'h004F, MAC_B, "R10 static kept");
    gnext(6'h01, 16'h0000, ONES,  "R10 dynamic gone");
    set_mac(ONES);
    gnext(6'h02, 16'h0015, MAC_D, "R9 other db kept");

    // R11 move port 2 -> 5 everywhere
    fm(3'd1, 6'h00, 16'h052F, "R11 move");
    set_mac(ONES);
    gnext(6'h01, 16'h020F, MAC_B, "R11 moved");
    set_mac(ONES);
    gnext(6'h12, 16'h0227, MAC_D, "R11 untouched");

    // R12 remove port 5
    fm(3'd1, 6'h00, 16'h0F5F, "R12 remove");
    set_mac(ONES);
    gnext(6'h01, 16'h0000, ONES,  "R12 emptied deleted");
    set_mac(ONES);
    gnext(6'h12, 16'h0027, MAC_D, "R12 bit cleared");

    // R9 flush everything
    fm(3'd1, 6'h00, 16'h0000, "R9 flush all");
    set_mac(ONES);
    gnext(6'h02, 16'h0000, ONES, "R9 db2 empty");
    set_mac(ONES);
    gnext(6'h12, 16'h0000, ONES, "R9 db12 empty");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule